// File: doc/BRIEF.md
# Multi-Source Watchdog with Guarded Clock Switchover

This block is a watchdog timer whose 16-bit counter can advance from one of four time bases. The first is the bus clock itself. The other three are a slow low-power oscillator of about 1 kHz, a 32 kHz internal clock and an external clock. Each of the three alternate clocks is asynchronous to the bus clock. It passes through a synchronizer, and its edges become single-cycle enables in the bus-clock domain. A fixed divide-by-256 stage can be placed in front of the counter for any of the four sources. When the counter reaches the programmed limit, the block issues a one-cycle reset pulse. A refresh strobe from software restarts the count.

Configuration follows a window scheme. After reset, and after each unlock strobe, there is a window of 128 bus clocks in which writes are captured into a shadow copy. When the window closes, the shadow copy becomes the active setting. If the time base changed, the counter is held at zero first for five edges of the old source and then for five edges of the new source. Only after that does counting resume. The hold gives both clock domains time to settle before the new source drives the count. All pins are plain control and status signals, with no streaming handshake.

Top module: `wdt_multisrc`

## Requirements
- R1: After reset, `count_o` and `wd_rst_o` are 0, the active source is the low-power oscillator (code 1), the divider is off and the limit is 4. Untouched, the first reset pulse comes after the fourth rising edge of `lpo_clk_i`.
- R2: Source codes on `cfg_src_i` are: 0 = bus clock (one tick per bus cycle), 1 = `lpo_clk_i`, 2 = `slow_clk_i`, 3 = `ext_clk_i`. An alternate source ticks once per synchronized rising edge.
- R3: With `cfg_div_i` = 1, the counter advances once per 256 ticks of the selected source.
- R4: When the counter would step onto the limit, `wd_rst_o` is high for one bus cycle, `count_o` returns to 0, and counting goes on. Pulses are spaced by exactly the limit in counter ticks.
- R5: A `kick_i` strobe outside a switchover hold sets `count_o` to 0 on the next edge.
- R6: Writes are captured only while the configuration window is open. The window lasts 128 bus clocks from reset or from an unlock strobe, and captured values become active when it closes.
- R7: A write made while the window is closed has no effect on the active configuration.
- R8: When the source changes at window close, `count_o` stays 0 through five edges (both directions) of the old source and then five edges of the new source. The bus clock counts one edge per cycle.
- R9: When the window closes with a change to the divider or the limit but not to the source, the prescaler and counter are cleared in that cycle and counting restarts on the next tick, with no hold.
- R10: A limit of 0 written in the window is stored as 1, which gives a reset pulse on every counter tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lpo_clk_i | input | 1 | About 1 kHz low-power oscillator, asynchronous |
| slow_clk_i | input | 1 | 32 kHz internal clock, asynchronous |
| ext_clk_i | input | 1 | External clock, asynchronous |
| cfg_unlock_i | input | 1 | Reopens the configuration window |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_src_i | input | 2 | Source code to write |
| cfg_div_i | input | 1 | Divide-by-256 enable to write |
| cfg_limit_i | input | 16 | Timeout limit to write, in counter ticks |
| kick_i | input | 1 | Refresh strobe |
| count_o | output | 16 | Current counter value |
| wd_rst_o | output | 1 | One-cycle watchdog reset pulse |

## Verification
The hardest behaviour to reach from the ports is the two-phase switchover hold. It only starts at the close of a window in which the source code differed from the active one. Its length depends on edge arrivals in two unrelated clock domains. The bench runs the three alternate clocks at distinct periods, offset so that they never line up with a bus edge. It first switches from the bus clock to the external clock and then from the external clock to the 32 kHz clock. At fixed cycle counts after window close, it checks that the counter is still zero where an unheld counter would already have advanced. It then checks that counting resumes within a bounded time.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int CNT_W = 16;

  typedef enum logic [1:0] {
    SRC_BUS  = 2'd0,
    SRC_LPO  = 2'd1,
    SRC_SLOW = 2'd2,
    SRC_EXT  = 2'd3
  } wdt_src_e;

  typedef enum logic [1:0] {
    HS_IDLE = 2'd0,
    HS_OLD  = 2'd1,
    HS_NEW  = 2'd2
  } hold_state_e;

  typedef struct packed {
    wdt_src_e         src;
    logic             div_en;
    logic [CNT_W-1:0] limit;
  } wdt_cfg_t;

  localparam wdt_cfg_t CFG_RESET = '{src: SRC_LPO, div_en: 1'b0, limit: CNT_W'(4)};
endpackage

// File: rtl/wdt_edge_sync.sv
module wdt_edge_sync #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] edge_o
);
  // Per input: two synchronizing flops plus one history flop for edge detection.
  for (genvar g = 0; g < N; g++) begin : g_chan
    logic [2:0] sh;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[1:0], async_i[g]};
    end
    assign rise_o[g] = sh[1] & ~sh[2];
    assign edge_o[g] = sh[1] ^ sh[2];
  end
endmodule

// File: rtl/wdt_cfg_window.sv
module wdt_cfg_window
  import wdt_pkg::*;
#(
  parameter int WIN = 128
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     unlock_i,
  input  logic     we_i,
  input  wdt_cfg_t wr_cfg_i,
  output wdt_cfg_t active_o,
  output wdt_cfg_t shadow_o,
  output logic     apply_o,
  output logic     src_chg_o,
  output logic     any_chg_o
);
  localparam int WIN_W = (WIN > 1) ? $clog2(WIN) : 1;

  logic             open_q;
  logic [WIN_W-1:0] left_q;
  wdt_cfg_t         act_q, shd_q;

  assign apply_o   = open_q && (left_q == '0);
  assign src_chg_o = apply_o && (shd_q.src != act_q.src);
  assign any_chg_o = apply_o && (shd_q != act_q);
  assign active_o  = act_q;
  assign shadow_o  = shd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b1;
      left_q <= WIN_W'(WIN - 1);
      act_q  <= CFG_RESET;
      shd_q  <= CFG_RESET;
    end else if (open_q) begin
      if (left_q == '0) begin
        open_q <= 1'b0;
        act_q  <= shd_q;
      end else begin
        left_q <= left_q - 1'b1;
        if (we_i) begin
          shd_q.src    <= wr_cfg_i.src;
          shd_q.div_en <= wr_cfg_i.div_en;
          shd_q.limit  <= (wr_cfg_i.limit == '0) ? CNT_W'(1) : wr_cfg_i.limit;
        end
      end
    end else if (unlock_i) begin
      open_q <= 1'b1;
      left_q <= WIN_W'(WIN - 1);
    end
  end
endmodule

// File: rtl/wdt_switch_seq.sv
module wdt_switch_seq
  import wdt_pkg::*;
#(
  parameter int HOLD_EDGES = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  wdt_src_e   old_src_i,
  input  wdt_src_e   new_src_i,
  input  logic [3:0] evt_i,
  output logic       hold_o
);
  localparam int EC_W = $clog2(HOLD_EDGES + 1);

  hold_state_e     st_q;
  wdt_src_e        old_q, new_q;
  logic [EC_W-1:0] ecnt_q;
  logic            evt;

  assign evt    = (st_q == HS_OLD) ? evt_i[old_q] : evt_i[new_q];
  assign hold_o = (st_q != HS_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= HS_IDLE;
      old_q  <= SRC_BUS;
      new_q  <= SRC_BUS;
      ecnt_q <= '0;
    end else if (start_i) begin
      st_q   <= HS_OLD;
      old_q  <= old_src_i;
      new_q  <= new_src_i;
      ecnt_q <= '0;
    end else if (st_q != HS_IDLE && evt) begin
      if (ecnt_q == EC_W'(HOLD_EDGES - 1)) begin
        ecnt_q <= '0;
        st_q   <= (st_q == HS_OLD) ? HS_NEW : HS_IDLE;
      end else begin
        ecnt_q <= ecnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
#(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_tick_i,
  input  logic             div_en_i,
  input  logic [CNT_W-1:0] limit_i,
  input  logic             hold_i,
  input  logic             clr_i,
  input  logic             kick_i,
  output logic [CNT_W-1:0] count_o,
  output logic             bite_o
);
  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q, nxt;
  logic             bite_q, cnt_tick;

  assign cnt_tick = div_en_i ? (src_tick_i && (pre_q == '1)) : src_tick_i;
  assign nxt      = cnt_q + 1'b1;
  assign count_o  = cnt_q;
  assign bite_o   = bite_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      cnt_q  <= '0;
      bite_q <= 1'b0;
    end else begin
      bite_q <= 1'b0;
      if (clr_i || hold_i) begin
        pre_q <= '0;
        cnt_q <= '0;
      end else begin
        if (div_en_i && src_tick_i) pre_q <= pre_q + 1'b1;
        if (kick_i) begin
          cnt_q <= '0;
        end else if (cnt_tick) begin
          if (nxt == limit_i) begin
            cnt_q  <= '0;
            bite_q <= 1'b1;
          end else begin
            cnt_q <= nxt;
          end
        end
      end
    end
  end
endmodule

// File: rtl/wdt_multisrc.sv
module wdt_multisrc
  import wdt_pkg::*;
#(
  parameter int CFG_WIN    = 128,
  parameter int HOLD_EDGES = 5,
  parameter int PRE_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lpo_clk_i,
  input  logic             slow_clk_i,
  input  logic             ext_clk_i,
  input  logic             cfg_unlock_i,
  input  logic             cfg_we_i,
  input  logic [1:0]       cfg_src_i,
  input  logic             cfg_div_i,
  input  logic [CNT_W-1:0] cfg_limit_i,
  input  logic             kick_i,
  output logic [CNT_W-1:0] count_o,
  output logic             wd_rst_o
);
  logic [2:0] alt_rise, alt_edge;
  logic [3:0] tick_vec, evt_vec;
  wdt_cfg_t   wr_cfg, act_cfg, shd_cfg;
  logic       apply_w, src_chg_w, any_chg_w, hold_w, src_tick;

  assign wr_cfg = '{src: wdt_src_e'(cfg_src_i), div_en: cfg_div_i, limit: cfg_limit_i};

  wdt_edge_sync #(.N(3)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_i({ext_clk_i, slow_clk_i, lpo_clk_i}),
    .rise_o(alt_rise), .edge_o(alt_edge)
  );

  // Index 0 is the bus clock: one tick and one hold event per cycle.
  assign tick_vec = {alt_rise, 1'b1};
  assign evt_vec  = {alt_edge, 1'b1};
  assign src_tick = tick_vec[act_cfg.src];

  wdt_cfg_window #(.WIN(CFG_WIN)) u_win (
    .clk(clk), .rst_n(rst_n),
    .unlock_i(cfg_unlock_i), .we_i(cfg_we_i), .wr_cfg_i(wr_cfg),
    .active_o(act_cfg), .shadow_o(shd_cfg),
    .apply_o(apply_w), .src_chg_o(src_chg_w), .any_chg_o(any_chg_w)
  );

  wdt_switch_seq #(.HOLD_EDGES(HOLD_EDGES)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .start_i(src_chg_w), .old_src_i(act_cfg.src), .new_src_i(shd_cfg.src),
    .evt_i(evt_vec), .hold_o(hold_w)
  );

  wdt_counter #(.PRE_W(PRE_W)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .src_tick_i(src_tick), .div_en_i(act_cfg.div_en), .limit_i(act_cfg.limit),
    .hold_i(hold_w), .clr_i(any_chg_w), .kick_i(kick_i),
    .count_o(count_o), .bite_o(wd_rst_o)
  );
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker
  import wdt_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             kick_i,
  input logic [CNT_W-1:0] count_i,
  input logic             bite_i,
  input logic             hold_i,
  input logic [CNT_W-1:0] limit_i,
  input logic             src_chg_i
);
  AST_BITE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bite_i |-> count_i == '0); // R4
  AST_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    count_i < limit_i); // R4
  AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |-> count_i == '0); // R8
  AST_SWITCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    src_chg_i |=> hold_i); // R8
  AST_KICK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (kick_i && !hold_i) |=> count_i == '0); // R5
  AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (count_i == '0 || count_i == $past(count_i) || count_i == $past(count_i) + 1'b1)); // R3
endmodule

bind wdt_multisrc wdt_checker u_chk (
  .clk(clk), .rst_n(rst_n), .kick_i(kick_i), .count_i(count_o), .bite_i(wd_rst_o),
  .hold_i(hold_w), .limit_i(act_cfg.limit), .src_chg_i(src_chg_w)
);

// File: tb/wdt_multisrc_bench.sv
module wdt_multisrc_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LPO_HALF   = 200;
  localparam int SLOW_HALF  = 70;
  localparam int EXT_HALF   = 30;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        lpo = 1'b0, slow = 1'b0, ext = 1'b0;
  logic        unlock = 1'b0, we = 1'b0, div = 1'b0, kick = 1'b0;
  logic [1:0]  src = 2'd0;
  logic [15:0] lim = 16'd0;
  logic [15:0] count_o;
  logic        wd_rst_o;
  int          checks = 0, fails = 0;

  wdt_multisrc u_wdt_multisrc (
    .clk(clk), .rst_n(rst_n), .lpo_clk_i(lpo), .slow_clk_i(slow), .ext_clk_i(ext),
    .cfg_unlock_i(unlock), .cfg_we_i(we), .cfg_src_i(src), .cfg_div_i(div),
    .cfg_limit_i(lim), .kick_i(kick), .count_o(count_o), .wd_rst_o(wd_rst_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  initial begin #3; forever #(LPO_HALF)  lpo  = ~lpo;  end
  initial begin #3; forever #(SLOW_HALF) slow = ~slow; end
  initial begin #3; forever #(EXT_HALF)  ext  = ~ext;  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Counts negedges until a pulse is seen; -1 if none within max.
  task automatic wait_pulse(input int max, output int n);
    n = -1;
    for (int i = 0; i < max; i++) begin
      @(negedge clk);
      if (wd_rst_o) begin n = i + 1; break; end
    end
  endtask

  // Unlock, write one setting, and stop at the negedge after window close.
  task automatic program_cfg(input logic [1:0] s, input logic d, input logic [15:0] l);
    @(negedge clk); unlock = 1'b1;
    @(negedge clk); unlock = 1'b0; we = 1'b1; src = s; div = d; lim = l;
    @(negedge clk); we = 1'b0;
    repeat (127) @(negedge clk);
  endtask

  task automatic t_reset_default();
    int n;
    repeat (5) @(negedge clk);
    chk(count_o == 0 && wd_rst_o == 0, "R1 reset outputs", count_o, 0);
    rst_n = 1'b1;
    wait_pulse(170, n);
    chk(n > 115 && n <= 170, "R1 first pulse after 4 lpo edges", n, 160);
  endtask

  task automatic t_window_apply();
    int n;
    program_cfg(2'd0, 1'b0, 16'd10);
    wait_pulse(400, n);
    chk(n != -1, "R6 new setting takes effect", n, 1);
    wait_pulse(20, n);
    chk(n == 10, "R4 pulse spacing equals limit", n, 10);
    @(negedge clk);
    chk(count_o == 1, "R4 counter restarts from zero", count_o, 1);
    wait_pulse(20, n);
    chk(n == 9, "R4 spacing after restart", n, 9);
  endtask

  task automatic t_closed_write();
    int n;
    @(negedge clk); we = 1'b1; src = 2'd0; div = 1'b0; lim = 16'd20;
    @(negedge clk); we = 1'b0;
    wait_pulse(20, n);
    wait_pulse(30, n);
    chk(n == 10, "R7 write outside window ignored", n, 10);
  endtask

  task automatic t_kick();
    int n;
    wait_pulse(20, n);
    repeat (4) @(negedge clk);
    chk(count_o == 4, "R5 count before kick", count_o, 4);
    kick = 1'b1;
    @(negedge clk); kick = 1'b0;
    chk(count_o == 0, "R5 kick clears counter", count_o, 0);
    @(negedge clk);
    chk(count_o == 1, "R5 counting resumes after kick", count_o, 1);
  endtask

  task automatic t_zero_limit();
    int n;
    program_cfg(2'd0, 1'b0, 16'd0);
    wait_pulse(20, n);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(wd_rst_o == 1'b1, "R10 zero limit pulses every tick", wd_rst_o, 1);
    end
  endtask

  task automatic t_prescale();
    int n;
    program_cfg(2'd0, 1'b1, 16'd2);
    repeat (200) @(negedge clk);
    chk(count_o == 0, "R3 no step before 256 ticks", count_o, 0);
    wait_pulse(600, n);
    wait_pulse(600, n);
    chk(n == 512, "R3 divided pulse spacing", n, 512);
  endtask

  task automatic t_prescale_only();
    program_cfg(2'd0, 1'b0, 16'd1000);
    chk(count_o == 0, "R9 counter cleared at window close", count_o, 0);
    repeat (2) @(negedge clk);
    chk(count_o == 2, "R9 counting resumes without hold", count_o, 2);
  endtask

  task automatic t_switch_hold();
    int n;
    program_cfg(2'd3, 1'b0, 16'd1000);
    chk(count_o == 0, "R8 counter zero at switch", count_o, 0);
    repeat (12) @(negedge clk);
    chk(count_o == 0, "R8 counter held through both phases", count_o, 0);
    n = -1;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (count_o != 0) begin n = i; break; end
    end
    chk(n != -1, "R8 counting resumes after hold", n, 1);
  endtask

  task automatic t_slow_source();
    int n;
    program_cfg(2'd2, 1'b0, 16'd3);
    wait_pulse(300, n);
    wait_pulse(100, n);
    chk(n == 42, "R2 slow source spacing 3 x 14 cycles", n, 42);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog timeout actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset_default();
    t_window_apply();
    t_closed_write();
    t_kick();
    t_zero_limit();
    t_prescale();
    t_prescale_only();
    t_switch_hold();
    t_slow_source();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule